// File: doc/BRIEF.md
# Secure Low-Power Real-Time Counter

This block keeps wall-clock time in an always-on domain. A slow clock (nominally 32768 Hz) advances a count whose upper 32 bits are whole seconds and whose lower `FRAC_W` bits are a sub-second fraction. The block cannot count until software walks it out of reset. The first step leaves the init state and enters the non-valid state. The second step leaves the non-valid state and enters the valid state. The count runs only in the valid state.

Several functions sit beside the count:
- a seconds alarm comparator that drives an interrupt line,
- a status register whose flags are cleared by writing one,
- a supply-glitch check word that must hold a fixed key,
- a scratch register.

Software reaches the block over a simple synchronous register bus in a faster bus clock domain. Each write is held in the bus domain and handed to the slow domain by a toggle handshake. The `wr_pending` output stays high until the slow domain has applied the write. Read data is registered and appears one bus cycle after the read strobe.

Top module: `lp_sec_rtc`

## Requirements
- R1: After reset the status word reads 0x0002. Its fields are:
  - bit 1: glitch flag, set because the check word starts at zero;
  - bits 13:12: lifecycle, 00 for init;
  - all other fields are zero.

  After reset the control register (0x10) and seconds (0x00) read zero, and `wr_pending` and `irq` are low.
- R2: A write accepted while `wr_pending` is low raises `wr_pending` in the next bus cycle. The slow domain applies the write within 3 slow-clock cycles, and then `wr_pending` falls. A write strobe seen while `wr_pending` is high is dropped.
- R3: Writing offset 0x00 loads the seconds and clears the fraction. Offset 0x04 returns the fraction left-aligned in bits 31:(32-FRAC_W), which is bits 31:17 for the default 15 bits, with zeros below.
- R4: While control bit 8 (time lock) is set, writes to offset 0x00 leave the count unchanged.
- R5: In init, a control write with bit 15 set moves the lifecycle to non-valid (01) and sets status bit 15. In non-valid, a control write with bit 14 and bit 3 both set moves it to valid (11) and sets status bit 14. Bit 14 without bit 3 leaves the state unchanged.
- R6: In the valid state the count advances by exactly one per slow-clock cycle. In init and non-valid it holds.
- R7: Status bit 1 (glitch) is set on every slow cycle in which the check word at offset 0x18 differs from 0x41736166. It can be cleared only while the word matches.
- R8: Writing status (0x14) clears each flag in bits 1, 3, 5, 14 and 15 whose data bit is one. A zero data bit leaves the flag as it was.
- R9: In the valid state, whenever the seconds equal the alarm register (0x08), status bit 3 (alarm) is set.
- R10: `irq` is high one slow cycle after the alarm flag, control bit 7 (alarm interrupt enable) and control bit 4 (wake enable) are all set. It is low otherwise.
- R11: When the count wraps from all ones to zero, status bit 5 (rollover) is set.
- R12: A control write with bit 0 set is a soft reset. It clears the count, the alarm, the control register and the alarm, rollover and lifecycle-done flags, and returns the lifecycle to init.
- R13: Read data is registered. Offset 0x0C reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset, bus domain; also resynchronised into the slow domain |
| slow_clk | input | 1 | Slow timekeeping clock |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| wr_pending | output | 1 | A write is in flight to the slow domain |
| irq | output | 1 | Alarm interrupt |

## Verification
The counter is tried in three ways:
- It is held in init and non-valid, where two fraction reads a known number of slow cycles apart must match exactly.
- It is released into valid, where the same spacing must show an exact step count.
- It is loaded with all-ones seconds, so the wrap and rollover flag are reached without a long wait.

The alarm is tried with the enable bits set in turn, each combination on its own, to separate the flag from the interrupt gating. Lifecycle writes that lack the enable bit are checked against writes that carry it, and a second write strobe issued while the first is still crossing shows that the dropping rule is kept. A behavioural model of the visible registers and interrupt enables is checked against the outputs on every bus clock.

// File: rtl/lprtc_pkg.sv
package lprtc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFS_SEC    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_FRAC   = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_ALARM  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_MONO   = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_GLITCH = 5'h18;
  localparam logic [ADDR_W-1:0] OFS_GP     = 5'h1C;

  // control bit positions
  localparam int CB_SWRST     = 0;
  localparam int CB_EN        = 3;
  localparam int CB_WAKE      = 4;
  localparam int CB_ALM_IE    = 7;
  localparam int CB_LOCK      = 8;
  localparam int CB_NV_EXIT   = 14;
  localparam int CB_INIT_EXIT = 15;

  // status bit positions
  localparam int ST_GLITCH    = 1;
  localparam int ST_ALM       = 3;
  localparam int ST_ROLL      = 5;
  localparam int ST_NV_DONE   = 14;
  localparam int ST_INIT_DONE = 15;

  localparam logic [DATA_W-1:0] GLITCH_KEY = 32'h4173_6166;

  typedef enum logic [1:0] {
    LIFE_INIT  = 2'b00,
    LIFE_NV    = 2'b01,
    LIFE_VALID = 2'b11
  } life_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_cmd_t;
endpackage

// File: rtl/lprtc_wr_xing.sv
module lprtc_wr_xing
  import lprtc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    cmd_valid,
  input  wr_cmd_t cmd_in,
  output logic    pending,
  input  logic    slow_clk,
  input  logic    srst,
  output logic    apply,
  output wr_cmd_t cmd_out
);
  localparam int TOP = SYNC_STAGES - 1;

  wr_cmd_t               hold_q;
  logic                  req_tgl_q;
  logic [SYNC_STAGES-1:0] ack_sync_q;
  logic [SYNC_STAGES-1:0] req_sync_q;
  logic                  seen_q;
  logic                  ack_tgl_q;

  // bus side: capture, toggle, wait for the acknowledge toggle
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q     <= '0;
      req_tgl_q  <= 1'b0;
      pending    <= 1'b0;
      ack_sync_q <= '0;
    end else begin
      ack_sync_q <= {ack_sync_q[TOP-1:0], ack_tgl_q};
      if (cmd_valid && !pending) begin
        hold_q    <= cmd_in;
        req_tgl_q <= ~req_tgl_q;
        pending   <= 1'b1;
      end else if (pending && (ack_sync_q[TOP] == req_tgl_q)) begin
        pending <= 1'b0;
      end
    end
  end

  // slow side: synchronise the toggle, one-cycle apply strobe, echo back
  assign apply   = req_sync_q[TOP] ^ seen_q;
  assign cmd_out = hold_q;

  always_ff @(posedge slow_clk) begin
    if (srst) begin
      req_sync_q <= '0;
      seen_q     <= 1'b0;
      ack_tgl_q  <= 1'b0;
    end else begin
      req_sync_q <= {req_sync_q[TOP-1:0], req_tgl_q};
      seen_q     <= req_sync_q[TOP];
      ack_tgl_q  <= ack_tgl_q ^ apply;
    end
  end
endmodule

// File: rtl/lprtc_life.sv
module lprtc_life
  import lprtc_pkg::*;
(
  input  logic  slow_clk,
  input  logic  srst,
  input  logic  soft_rst,
  input  logic  ctrl_wr,
  input  logic  req_init_exit,
  input  logic  req_nv_exit,
  input  logic  req_enable,
  output life_e state,
  output logic  init_exit_evt,
  output logic  nv_exit_evt
);
  always_comb begin
    init_exit_evt = ctrl_wr && !soft_rst && (state == LIFE_INIT) && req_init_exit;
    nv_exit_evt   = ctrl_wr && !soft_rst && (state == LIFE_NV) && req_nv_exit && req_enable;
  end

  always_ff @(posedge slow_clk) begin
    if (srst || soft_rst) state <= LIFE_INIT;
    else if (init_exit_evt) state <= LIFE_NV;
    else if (nv_exit_evt) state <= LIFE_VALID;
  end
endmodule

// File: rtl/lprtc_core.sv
module lprtc_core
  import lprtc_pkg::*;
#(
  parameter  int FRAC_W = 15,
  localparam int CNT_W  = DATA_W + FRAC_W
) (
  input  logic              slow_clk,
  input  logic              srst,
  input  logic              apply,
  input  wr_cmd_t           cmd,
  input  life_e             state,
  input  logic              init_exit_evt,
  input  logic              nv_exit_evt,
  output logic              soft_rst,
  output logic              ctrl_wr,
  output logic [CNT_W-1:0]  count_q,
  output logic [DATA_W-1:0] alarm_q,
  output logic [15:0]       ctrl_q,
  output logic [DATA_W-1:0] glitch_q,
  output logic [DATA_W-1:0] gp_q,
  output logic              f_glitch_q,
  output logic              f_alm_q,
  output logic              f_roll_q,
  output logic              f_init_q,
  output logic              f_nv_q,
  output logic              irq_q
);
  logic sec_wr, alm_wr, stat_wr, gw_wr, gp_wr, load, alm_hit, wrap;

  always_comb begin
    sec_wr   = apply && (cmd.addr == OFS_SEC);
    alm_wr   = apply && (cmd.addr == OFS_ALARM);
    ctrl_wr  = apply && (cmd.addr == OFS_CTRL);
    stat_wr  = apply && (cmd.addr == OFS_STAT);
    gw_wr    = apply && (cmd.addr == OFS_GLITCH);
    gp_wr    = apply && (cmd.addr == OFS_GP);
    soft_rst = ctrl_wr && cmd.data[CB_SWRST];
    load     = sec_wr && !ctrl_q[CB_LOCK];
    alm_hit  = (state == LIFE_VALID) && (count_q[CNT_W-1:FRAC_W] == alarm_q);
    wrap     = (state == LIFE_VALID) && !load && (&count_q);
  end

  always_ff @(posedge slow_clk) begin
    if (srst) begin
      count_q    <= '0;
      alarm_q    <= '0;
      ctrl_q     <= '0;
      glitch_q   <= '0;
      gp_q       <= '0;
      f_glitch_q <= 1'b1;
      f_alm_q    <= 1'b0;
      f_roll_q   <= 1'b0;
      f_init_q   <= 1'b0;
      f_nv_q     <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      if (soft_rst) count_q <= '0;
      else if (load) count_q <= {cmd.data, {FRAC_W{1'b0}}};
      else if (state == LIFE_VALID) count_q <= count_q + CNT_W'(1);

      if (soft_rst) alarm_q <= '0;
      else if (alm_wr) alarm_q <= cmd.data;

      if (soft_rst) ctrl_q <= '0;
      else if (ctrl_wr) ctrl_q <= {cmd.data[15:1], 1'b0};

      if (gw_wr) glitch_q <= cmd.data;
      if (gp_wr) gp_q <= cmd.data;

      // set wins over clear; soft reset drops the timekeeping flags
      f_glitch_q <= (glitch_q != GLITCH_KEY) ||
                    (f_glitch_q && !(stat_wr && cmd.data[ST_GLITCH]));
      f_alm_q    <= alm_hit ||
                    (f_alm_q && !soft_rst && !(stat_wr && cmd.data[ST_ALM]));
      f_roll_q   <= wrap ||
                    (f_roll_q && !soft_rst && !(stat_wr && cmd.data[ST_ROLL]));
      f_init_q   <= init_exit_evt ||
                    (f_init_q && !soft_rst && !(stat_wr && cmd.data[ST_INIT_DONE]));
      f_nv_q     <= nv_exit_evt ||
                    (f_nv_q && !soft_rst && !(stat_wr && cmd.data[ST_NV_DONE]));

      irq_q <= f_alm_q && ctrl_q[CB_ALM_IE] && ctrl_q[CB_WAKE];
    end
  end
endmodule

// File: rtl/lp_sec_rtc.sv
module lp_sec_rtc
  import lprtc_pkg::*;
#(
  parameter int FRAC_W      = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              slow_clk,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              wr_pending,
  output logic              irq
);
  localparam int CNT_W = DATA_W + FRAC_W;
  localparam int PAD_W = DATA_W - FRAC_W;

  // reset into the slow domain, asserted from power-up
  logic [SYNC_STAGES-1:0] srst_pipe = '1;
  logic                   srst;
  always_ff @(posedge slow_clk) srst_pipe <= {srst_pipe[SYNC_STAGES-2:0], rst};
  assign srst = srst_pipe[SYNC_STAGES-1];

  wr_cmd_t           cmd;
  logic              apply, soft_rst, ctrl_wr, init_exit_evt, nv_exit_evt;
  life_e             life_state;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] alarm, glitch_word, gp;
  logic [15:0]       ctrl;
  logic              f_glitch, f_alm, f_roll, f_init, f_nv;

  lprtc_wr_xing #(.SYNC_STAGES(SYNC_STAGES)) u_xing (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (bus_wr),
    .cmd_in    ('{addr: bus_addr, data: bus_wdata}),
    .pending   (wr_pending),
    .slow_clk  (slow_clk),
    .srst      (srst),
    .apply     (apply),
    .cmd_out   (cmd)
  );

  lprtc_life u_life (
    .slow_clk      (slow_clk),
    .srst          (srst),
    .soft_rst      (soft_rst),
    .ctrl_wr       (ctrl_wr),
    .req_init_exit (cmd.data[CB_INIT_EXIT]),
    .req_nv_exit   (cmd.data[CB_NV_EXIT]),
    .req_enable    (cmd.data[CB_EN]),
    .state         (life_state),
    .init_exit_evt (init_exit_evt),
    .nv_exit_evt   (nv_exit_evt)
  );

  lprtc_core #(.FRAC_W(FRAC_W)) u_core (
    .slow_clk      (slow_clk),
    .srst          (srst),
    .apply         (apply),
    .cmd           (cmd),
    .state         (life_state),
    .init_exit_evt (init_exit_evt),
    .nv_exit_evt   (nv_exit_evt),
    .soft_rst      (soft_rst),
    .ctrl_wr       (ctrl_wr),
    .count_q       (count),
    .alarm_q       (alarm),
    .ctrl_q        (ctrl),
    .glitch_q      (glitch_word),
    .gp_q          (gp),
    .f_glitch_q    (f_glitch),
    .f_alm_q       (f_alm),
    .f_roll_q      (f_roll),
    .f_init_q      (f_init),
    .f_nv_q        (f_nv),
    .irq_q         (irq)
  );

  logic [DATA_W-1:0] status_word;
  assign status_word = {16'h0, f_init, f_nv, 2'(life_state), 6'b0,
                        f_roll, 1'b0, f_alm, 1'b0, f_glitch, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        OFS_SEC:    bus_rdata <= count[CNT_W-1 -: DATA_W];
        OFS_FRAC:   bus_rdata <= {count[FRAC_W-1:0], {PAD_W{1'b0}}};
        OFS_ALARM:  bus_rdata <= alarm;
        OFS_CTRL:   bus_rdata <= {16'h0, ctrl};
        OFS_STAT:   bus_rdata <= status_word;
        OFS_GLITCH: bus_rdata <= glitch_word;
        OFS_GP:     bus_rdata <= gp;
        default:    bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/lprtc_chk.sv
module lprtc_chk
  import lprtc_pkg::*;
#(
  parameter int CNT_W = 47
) (
  input logic              clk,
  input logic              rst,
  input logic              slow_clk,
  input logic              srst,
  input logic              bus_wr,
  input logic              wr_pending,
  input logic              apply,
  input logic [ADDR_W-1:0] cmd_addr,
  input life_e             state,
  input logic [CNT_W-1:0]  count,
  input logic              lock,
  input logic              alm_ie,
  input logic              wake,
  input logic              f_alm,
  input logic              irq
);
  // R2: an accepted write shows as pending on the next bus cycle
  p_pending_rise_r2: assert property (@(posedge clk) disable iff (rst)
    bus_wr && !wr_pending |=> wr_pending);

  // R5, R12: lifecycle only steps forward one state or falls back to init
  p_life_order_r5: assert property (@(posedge slow_clk) disable iff (srst)
    state != $past(state) |->
      (state == LIFE_INIT) ||
      ($past(state) == LIFE_INIT && state == LIFE_NV) ||
      ($past(state) == LIFE_NV && state == LIFE_VALID));

  // R6: outside the valid state the count holds without a write
  p_hold_outside_valid_r6: assert property (@(posedge slow_clk) disable iff (srst)
    state != LIFE_VALID && !apply |=> $stable(count));

  // R6: in the valid state the count steps by one without a write
  p_step_in_valid_r6: assert property (@(posedge slow_clk) disable iff (srst)
    state == LIFE_VALID && !apply |=> count == $past(count) + CNT_W'(1));

  // R4: a locked seconds write leaves a held count alone
  p_lock_r4: assert property (@(posedge slow_clk) disable iff (srst)
    apply && cmd_addr == OFS_SEC && lock && state != LIFE_VALID |=> $stable(count));

  // R10: the interrupt follows flag and both enables one slow cycle late
  p_irq_gate_r10: assert property (@(posedge slow_clk) disable iff (srst)
    irq |-> $past(f_alm && alm_ie && wake));
endmodule

bind lp_sec_rtc lprtc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .slow_clk   (slow_clk),
  .srst       (srst),
  .bus_wr     (bus_wr),
  .wr_pending (wr_pending),
  .apply      (apply),
  .cmd_addr   (cmd.addr),
  .state      (life_state),
  .count      (count),
  .lock       (ctrl[8]),
  .alm_ie     (ctrl[7]),
  .wake       (ctrl[4]),
  .f_alm      (f_alm),
  .irq        (irq)
);

// File: tb/lp_sec_rtc_tb.sv
module lp_sec_rtc_tb;
  localparam int FW  = 8;
  localparam int SH  = 32 - FW;
  localparam logic [31:0] KEY = 32'h4173_6166;

  logic        clk = 1'b0;
  logic        slow_clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wr_pending, irq;

  int checks = 0;
  int errors = 0;

  // behavioural model of the software-visible state
  logic [31:0] mdl_ctrl = '0, mdl_alarm = '0, mdl_gp = '0;
  int acc_prev = 0, pend_cyc = 0, off_cyc = 0;

  always #4 clk = ~clk;
  initial begin
    #2;
    forever #16 slow_clk = ~slow_clk;
  end

  lp_sec_rtc #(.FRAC_W(FW)) u_dut (
    .clk(clk), .rst(rst), .slow_clk(slow_clk),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wr_pending(wr_pending), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] st(input bit ini, input bit nv, input logic [1:0] life,
                                     input bit roll, input bit alm, input bit gl);
    return {16'h0, ini, nv, life, 6'b0, roll, 1'b0, alm, 1'b0, gl, 1'b0};
  endfunction

  // every bus clock: pending behaviour and interrupt enables against the model
  always @(negedge clk) begin
    if (!rst) begin
      if (acc_prev != 0) chk("R2 pending after accept", {31'b0, wr_pending}, 32'd1);
      acc_prev = (bus_wr && !wr_pending) ? 1 : 0;
      if (wr_pending) begin
        pend_cyc++;
        if (pend_cyc == 25) chk("R2 pending bound", 32'd25, 32'd24);
      end else pend_cyc = 0;
      if (mdl_ctrl[7] && mdl_ctrl[4]) off_cyc = 0;
      else off_cyc++;
      if (off_cyc > 28) chk("R10 irq with enables off", {31'b0, irq}, 32'd0);
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    if (a == 5'h10) begin
      if (d[0]) begin mdl_ctrl = '0; mdl_alarm = '0; end
      else mdl_ctrl = {16'h0, d[15:1], 1'b0};
    end
    if (a == 5'h08) mdl_alarm = d;
    if (a == 5'h1C) mdl_gp = d;
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    @(negedge clk);
    while (wr_pending) @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, f1, f2, s;
    repeat (40) @(posedge clk);
    #1 rst = 1'b0;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(5'h14, v); chk("R1 status", v, st(0, 0, 2'b00, 0, 0, 1));
    rd(5'h10, v); chk("R1 control", v, 32'h0);
    rd(5'h00, v); chk("R1 seconds", v, 32'h0);
    chk("R1 pending", {31'b0, wr_pending}, 32'd0);
    chk("R1 irq", {31'b0, irq}, 32'd0);

    // R13 registered read, unused offset
    wr(5'h0C, 32'hDEAD_BEEF);
    rd(5'h0C, v); chk("R13 monotonic offset", v, 32'h0);

    // R8 zero leaves flag, R7 key gating
    wr(5'h14, 32'h0);
    rd(5'h14, v); chk("R8 zero write keeps glitch", v, st(0, 0, 2'b00, 0, 0, 1));
    wr(5'h14, 32'h2);
    rd(5'h14, v); chk("R7 clear without key", v, st(0, 0, 2'b00, 0, 0, 1));
    wr(5'h18, KEY);
    wr(5'h14, 32'h2);
    rd(5'h14, v); chk("R7 clear with key", v, st(0, 0, 2'b00, 0, 0, 0));
    wr(5'h18, 32'h1234);
    rd(5'h14, v); chk("R7 bad key sets", v, st(0, 0, 2'b00, 0, 0, 1));
    wr(5'h18, KEY);
    wr(5'h14, 32'h2);
    rd(5'h14, v); chk("R8 glitch cleared", v, st(0, 0, 2'b00, 0, 0, 0));

    // R2 second strobe during pending is dropped
    mdl_gp = 32'h11;
    @(posedge clk); #1; bus_wr = 1'b1; bus_addr = 5'h1C; bus_wdata = 32'h11;
    @(posedge clk); #1; bus_wdata = 32'h22;
    @(posedge clk); #1; bus_wr = 1'b0;
    @(negedge clk); while (wr_pending) @(negedge clk);
    rd(5'h1C, v); chk("R2 dropped write", v, mdl_gp);

    // R3 load, R6 frozen in init
    wr(5'h00, 32'd100);
    rd(5'h00, v); chk("R3 seconds load", v, 32'd100);
    rd(5'h04, f1); chk("R3 fraction cleared", f1, 32'h0);
    repeat (38) @(posedge clk);
    rd(5'h04, f2); chk("R6 frozen in init", f2, f1);

    // R4 lock
    wr(5'h10, 32'h100);
    wr(5'h00, 32'd555);
    rd(5'h00, v); chk("R4 locked seconds", v, 32'd100);
    rd(5'h10, v); chk("R4 control readback", v, mdl_ctrl);
    wr(5'h10, 32'h0);

    // R5 lifecycle
    wr(5'h10, 32'h8000);
    rd(5'h14, v); chk("R5 enter non-valid", v, st(1, 0, 2'b01, 0, 0, 0));
    wr(5'h10, 32'h4000);
    rd(5'h14, v); chk("R5 exit needs enable", v, st(1, 0, 2'b01, 0, 0, 0));
    rd(5'h04, f1);
    repeat (38) @(posedge clk);
    rd(5'h04, f2); chk("R6 frozen in non-valid", f2, f1);
    wr(5'h10, 32'hC008);
    rd(5'h14, v); chk("R5 enter valid", v, st(1, 1, 2'b11, 0, 0, 0));

    // R6 exact stepping
    rd(5'h04, f1);
    repeat (38) @(posedge clk);
    rd(5'h04, f2);
    chk("R6 ten slow cycles", {24'h0, 8'((f2 >> SH) - (f1 >> SH))}, 32'd10);

    // R9, R10 alarm and interrupt gating
    rd(5'h00, s);
    wr(5'h08, s + 32'd1);
    rd(5'h08, v); chk("R9 alarm readback", v, mdl_alarm);
    rd(5'h14, v); chk("R9 flag not yet", {31'b0, v[3]}, 32'd0);
    wr(5'h10, 32'h0008);
    repeat (1100) @(posedge clk);
    rd(5'h14, v); chk("R9 flag on match", {31'b0, v[3]}, 32'd1);
    chk("R10 irq needs enables", {31'b0, irq}, 32'd0);
    wr(5'h10, 32'h0098);
    repeat (8) @(posedge clk); @(negedge clk);
    chk("R10 irq raised", {31'b0, irq}, 32'd1);
    wr(5'h10, 32'h0088);
    repeat (8) @(posedge clk); @(negedge clk);
    chk("R10 irq needs wake", {31'b0, irq}, 32'd0);
    wr(5'h08, 32'h0);
    wr(5'h14, 32'h8);
    rd(5'h14, v); chk("R8 alarm cleared", {31'b0, v[3]}, 32'd0);

    // R11 rollover
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h14, v); chk("R11 no rollover yet", {31'b0, v[5]}, 32'd0);
    repeat (1100) @(posedge clk);
    rd(5'h14, v); chk("R11 rollover flag", {31'b0, v[5]}, 32'd1);
    rd(5'h00, v); chk("R11 seconds wrapped", v, 32'd0);
    wr(5'h14, 32'h20);
    rd(5'h14, v); chk("R8 rollover cleared", {31'b0, v[5]}, 32'd0);

    // R12 soft reset
    wr(5'h08, 32'd7);
    wr(5'h10, 32'h1);
    rd(5'h14, v); chk("R12 status after soft reset", v, st(0, 0, 2'b00, 0, 0, 0));
    rd(5'h00, v); chk("R12 seconds cleared", v, 32'd0);
    rd(5'h08, v); chk("R12 alarm cleared", v, mdl_alarm);
    rd(5'h10, v); chk("R12 control cleared", v, mdl_ctrl);
    repeat (40) @(posedge clk);
    rd(5'h04, v); chk("R12 held in init", v, 32'd0);
    rd(5'h1C, v); chk("R13 scratch kept", v, mdl_gp);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule